// File: doc/BRIEF.md
# Windowed Pixel Write Engine

This block takes a byte stream from a display-memory data port and places it, pixel by pixel, into a rectangular window of a frame buffer. Software first programs the window corners, an input format code and a source select. A transfer then starts either on the first data-port write or on a write to the source select. Each accepted data-port write carries one byte in its low half. Once a whole pixel has arrived, the engine expands it to 24-bit RGB and issues it on a frame-buffer write stream. The address of each pixel is its row times the panel width plus its column. The window is walked left to right, then top to bottom.

When the last byte of a window is accepted, the engine pulses a done flag. It also widens a dirty bounding box that the refresh logic reads and later acknowledges. Both streams use valid/ready. The data port is accepted only when the single output register is free or draining. A pixel that has been offered is held unchanged until it is taken.

Top module: `win_pixel_writer`

## Requirements
- R1: Bytes per pixel come from `fmt_code`. Code 1 (16-bit 5:6:5) takes 2 bytes. Codes 2 and 3 (18-bit and 24-bit packed) take 3 bytes. Codes 5 and 6 (18-bit and 24-bit padded) take 4 bytes. Every other code gives 0 bytes, which makes setup fail.
- R2: Setup fails when the source select is above 3, when the format gives 0 bytes, when `win_x1 < win_x0`, or when `win_y1 < win_y0`. After a failed setup no pixel is written and no done pulse occurs.
- R3: A data-port write accepted while no transfer is active attempts setup with the current window, format and stored source select. If setup succeeds, that byte is the first byte of the transfer. If setup fails, the byte is dropped.
- R4: A `src_sel_wr` pulse stores `src_sel` and re-runs setup. This abandons any transfer in progress, including a partly received pixel. `in_ready` is low in that cycle.
- R5: Each accepted data write supplies one byte from `in_data[7:0]`, and `in_data[15:8]` is ignored. A transfer consumes exactly bpp × (x1−x0+1) × (y1−y0+1) bytes and emits one pixel per bpp bytes.
- R6: For a 2-byte pixel, the first byte is the low half of the word. Blue is word bits 4:0 shifted left 3, green is bits 10:5 shifted left 2, and red is bits 15:11 shifted left 3. `pix_rgb` is {red, green, blue}.
- R7: For 3-byte and 4-byte pixels, the first byte is blue, the second is green and the third is red. The fourth byte of a 4-byte pixel is discarded.
- R8: `pix_addr` = row × PANEL_W + column, with pixels in raster order within the window.
- R9: `xfer_done` is high for exactly one cycle, in the cycle after the final byte of a window is accepted.
- R10: After reset the dirty box is empty: `dirty_x0`/`dirty_y0` are all ones and `dirty_x1`/`dirty_y1` are 0. On each completion, the minimum corners move down to the window start where that start is smaller. The maximum corners move up to end+1 where that is larger.
- R11: `dirty_ack` empties the box at the next edge. If a completion lands on the same edge, the box becomes exactly that window.
- R12: While `pix_valid` is high and `pix_ready` is low, `pix_addr` and `pix_rgb` hold steady and `in_ready` is low. With no pixel pending and no source-select write, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_x0 | input | COORD_W | Window start column |
| win_y0 | input | COORD_W | Window start row |
| win_x1 | input | COORD_W | Window end column (inclusive) |
| win_y1 | input | COORD_W | Window end row (inclusive) |
| fmt_code | input | 4 | Input pixel format code |
| src_sel | input | 3 | Data source select value |
| src_sel_wr | input | 1 | Source select write strobe, re-runs setup |
| in_valid | input | 1 | Data-port write valid |
| in_ready | output | 1 | Data-port write ready |
| in_data | input | 16 | Data-port write value, low byte used |
| pix_valid | output | 1 | Frame-buffer write valid |
| pix_ready | input | 1 | Frame-buffer write ready |
| pix_addr | output | ADDR_W | Frame-buffer pixel address |
| pix_rgb | output | 24 | Pixel as {R,G,B}, 8 bits each |
| xfer_done | output | 1 | One-cycle pulse when a window completes |
| dirty_ack | input | 1 | Refresh acknowledge, empties dirty box |
| dirty_x0 | output | COORD_W | Dirty box minimum column |
| dirty_y0 | output | COORD_W | Dirty box minimum row |
| dirty_x1 | output | COORD_W+1 | Dirty box column limit (exclusive) |
| dirty_y1 | output | COORD_W+1 | Dirty box row limit (exclusive) |

## Verification
The hardest case to reach from the ports is a refresh acknowledge that lands on the same clock edge as a window's final byte. In that case the box must be rebuilt from the completing window alone, not cleared. The stimulus holds `dirty_ack` high for exactly as long as the last data byte waits for acceptance. This forces the two events onto one edge even when the output stream is stalling. Stalls on `pix_ready` are also driven in a rotating pattern across a sweep of every format and several window shapes, including ones that touch the far corner of the coordinate range.

// File: rtl/wpw_pkg.sv
package wpw_pkg;
  localparam logic [3:0] FMT_565      = 4'h1;
  localparam logic [3:0] FMT_666_PACK = 4'h2;
  localparam logic [3:0] FMT_888_PACK = 4'h3;
  localparam logic [3:0] FMT_666_PAD  = 4'h5;
  localparam logic [3:0] FMT_888_PAD  = 4'h6;
  localparam logic [2:0] SRC_MAX      = 3'd3;

  function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
    case (code)
      FMT_565:                    fmt_bytes = 3'd2;
      FMT_666_PACK, FMT_888_PACK: fmt_bytes = 3'd3;
      FMT_666_PAD, FMT_888_PAD:   fmt_bytes = 3'd4;
      default:                    fmt_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/wpw_setup_check.sv
module wpw_setup_check #(
  parameter int COORD_W = 10
) (
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [3:0]         fmt,
  input  logic [2:0]         src,
  output logic               ok,
  output logic [2:0]         bpp
);
  import wpw_pkg::*;

  always_comb begin
    bpp = fmt_bytes(fmt);
    ok  = (src <= SRC_MAX) && (bpp != 3'd0) && (x1 >= x0) && (y1 >= y0);
  end
endmodule

// File: rtl/wpw_pixel_pack.sv
module wpw_pixel_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic [2:0]  bpp_in,
  input  logic        byte_en,
  input  logic [7:0]  byte_in,
  output logic        pix_done,
  output logic [23:0] rgb
);
  logic [1:0] idx_q;
  logic [2:0] bpp_q;
  logic [7:0] acc_q [3];
  logic [1:0] idx_eff;
  logic [2:0] bpp_eff;
  logic [15:0] word565;

  assign idx_eff  = restart ? 2'd0 : idx_q;
  assign bpp_eff  = restart ? bpp_in : bpp_q;
  assign pix_done = byte_en && ({1'b0, idx_eff} == (bpp_eff - 3'd1));
  assign word565  = {byte_in, acc_q[0]};

  always_comb begin
    if (bpp_eff == 3'd2)
      rgb = {word565[15:11], 3'b000, word565[10:5], 2'b00, word565[4:0], 3'b000};
    else if (bpp_eff == 3'd3)
      rgb = {byte_in, acc_q[1], acc_q[0]};
    else
      rgb = {acc_q[2], acc_q[1], acc_q[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bpp_q <= '0;
      for (int i = 0; i < 3; i++) acc_q[i] <= '0;
    end else begin
      if (restart) begin
        bpp_q <= bpp_in;
        idx_q <= '0;
      end
      if (byte_en) begin
        if (idx_eff != 2'd3) acc_q[idx_eff] <= byte_in;
        idx_q <= pix_done ? 2'd0 : idx_eff + 2'd1;
      end
    end
  end
endmodule

// File: rtl/wpw_walker.sv
module wpw_walker #(
  parameter int COORD_W = 10,
  parameter int PANEL_W = 640,
  parameter int ADDR_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               step,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  output logic [ADDR_W-1:0]  addr,
  output logic               at_last,
  output logic [COORD_W-1:0] lx0,
  output logic [COORD_W-1:0] ly0,
  output logic [COORD_W-1:0] lx1,
  output logic [COORD_W-1:0] ly1
);
  logic [COORD_W-1:0] col_q, row_q;
  logic [ADDR_W-1:0]  base_q;

  assign addr    = base_q + ADDR_W'(col_q);
  assign at_last = (col_q == lx1) && (row_q == ly1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0; row_q <= '0; base_q <= '0;
      lx0 <= '0; ly0 <= '0; lx1 <= '0; ly1 <= '0;
    end else if (start) begin
      lx0 <= x0; ly0 <= y0; lx1 <= x1; ly1 <= y1;
      col_q  <= x0;
      row_q  <= y0;
      base_q <= ADDR_W'(y0) * ADDR_W'(PANEL_W);
    end else if (step) begin
      if (col_q == lx1) begin
        col_q  <= lx0;
        row_q  <= row_q + 1'b1;
        base_q <= base_q + ADDR_W'(PANEL_W);
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpw_dirty_box.sv
module wpw_dirty_box #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic               ack,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  output logic [COORD_W-1:0] min_x,
  output logic [COORD_W-1:0] min_y,
  output logic [COORD_W:0]   max_x,
  output logic [COORD_W:0]   max_y
);
  logic [COORD_W-1:0] bmin_x, bmin_y;
  logic [COORD_W:0]   bmax_x, bmax_y, lim_x, lim_y;

  always_comb begin
    bmin_x = ack ? '1 : min_x;
    bmin_y = ack ? '1 : min_y;
    bmax_x = ack ? '0 : max_x;
    bmax_y = ack ? '0 : max_y;
    lim_x  = {1'b0, x1} + 1'b1;
    lim_y  = {1'b0, y1} + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_x <= '1; min_y <= '1; max_x <= '0; max_y <= '0;
    end else if (commit) begin
      min_x <= (x0 < bmin_x) ? x0 : bmin_x;
      min_y <= (y0 < bmin_y) ? y0 : bmin_y;
      max_x <= (lim_x > bmax_x) ? lim_x : bmax_x;
      max_y <= (lim_y > bmax_y) ? lim_y : bmax_y;
    end else if (ack) begin
      min_x <= '1; min_y <= '1; max_x <= '0; max_y <= '0;
    end
  end
endmodule

// File: rtl/win_pixel_writer.sv
module win_pixel_writer #(
  parameter int COORD_W = 10,
  parameter int PANEL_W = 640,
  parameter int ADDR_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] win_x0,
  input  logic [COORD_W-1:0] win_y0,
  input  logic [COORD_W-1:0] win_x1,
  input  logic [COORD_W-1:0] win_y1,
  input  logic [3:0]         fmt_code,
  input  logic [2:0]         src_sel,
  input  logic               src_sel_wr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [15:0]        in_data,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [ADDR_W-1:0]  pix_addr,
  output logic [23:0]        pix_rgb,
  output logic               xfer_done,
  input  logic               dirty_ack,
  output logic [COORD_W-1:0] dirty_x0,
  output logic [COORD_W-1:0] dirty_y0,
  output logic [COORD_W:0]   dirty_x1,
  output logic [COORD_W:0]   dirty_y1
);
  logic [2:0] src_q;
  logic [2:0] src_eff;
  logic       busy_q;
  logic       setup_ok;
  logic [2:0] setup_bpp;
  logic       accept, arm_data, start, byte_en;
  logic       pix_done, last_px;
  logic [23:0] rgb_next;
  logic [ADDR_W-1:0] walk_addr;
  logic       walk_last;
  logic [COORD_W-1:0] lx0, ly0, lx1, ly1;
  logic       unused_hi;

  assign unused_hi = ^in_data[15:8];
  assign src_eff   = src_sel_wr ? src_sel : src_q;
  assign in_ready  = !src_sel_wr && (!pix_valid || pix_ready);
  assign accept    = in_valid && in_ready;
  assign arm_data  = accept && !busy_q && setup_ok;
  assign start     = (src_sel_wr && setup_ok) || arm_data;
  assign byte_en   = accept && (busy_q || arm_data);
  assign last_px   = pix_done && busy_q && walk_last;

  wpw_setup_check #(.COORD_W(COORD_W)) u_check (
    .x0(win_x0), .y0(win_y0), .x1(win_x1), .y1(win_y1),
    .fmt(fmt_code), .src(src_eff), .ok(setup_ok), .bpp(setup_bpp)
  );

  wpw_pixel_pack u_pack (
    .clk(clk), .rst_n(rst_n), .restart(start), .bpp_in(setup_bpp),
    .byte_en(byte_en), .byte_in(in_data[7:0]),
    .pix_done(pix_done), .rgb(rgb_next)
  );

  wpw_walker #(.COORD_W(COORD_W), .PANEL_W(PANEL_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .step(pix_done && busy_q),
    .x0(win_x0), .y0(win_y0), .x1(win_x1), .y1(win_y1),
    .addr(walk_addr), .at_last(walk_last),
    .lx0(lx0), .ly0(ly0), .lx1(lx1), .ly1(ly1)
  );

  wpw_dirty_box #(.COORD_W(COORD_W)) u_dirty (
    .clk(clk), .rst_n(rst_n), .commit(last_px), .ack(dirty_ack),
    .x0(lx0), .y0(ly0), .x1(lx1), .y1(ly1),
    .min_x(dirty_x0), .min_y(dirty_y0), .max_x(dirty_x1), .max_y(dirty_y1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      busy_q    <= 1'b0;
      pix_valid <= 1'b0;
      pix_addr  <= '0;
      pix_rgb   <= '0;
      xfer_done <= 1'b0;
    end else begin
      if (src_sel_wr) src_q <= src_sel;
      if (src_sel_wr)    busy_q <= setup_ok;
      else if (arm_data) busy_q <= 1'b1;
      else if (last_px)  busy_q <= 1'b0;
      if (pix_done && busy_q) begin
        pix_valid <= 1'b1;
        pix_addr  <= walk_addr;
        pix_rgb   <= rgb_next;
      end else if (pix_ready) begin
        pix_valid <= 1'b0;
      end
      xfer_done <= last_px;
    end
  end
endmodule

// File: rtl/wpw_checker.sv
module wpw_checker #(
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               src_sel_wr,
  input logic               in_ready,
  input logic               pix_valid,
  input logic               pix_ready,
  input logic [ADDR_W-1:0]  pix_addr,
  input logic [23:0]        pix_rgb,
  input logic               xfer_done,
  input logic               dirty_ack,
  input logic [COORD_W-1:0] dirty_x0,
  input logic [COORD_W-1:0] dirty_y0,
  input logic [COORD_W:0]   dirty_x1,
  input logic [COORD_W:0]   dirty_y1
);
  AST_SRCWR_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel_wr |-> !in_ready); // R4

  AST_PIX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_addr) && $stable(pix_rgb)); // R12

  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid && !src_sel_wr |-> in_ready); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R9

  AST_BOX_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (dirty_x1 > {1'b0, dirty_x0}) && (dirty_y1 > {1'b0, dirty_y0})); // R10

  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_ack |=> xfer_done || ((&dirty_x0) && (&dirty_y0) && dirty_x1 == '0 && dirty_y1 == '0)); // R11
endmodule

bind win_pixel_writer wpw_checker #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel_wr(src_sel_wr), .in_ready(in_ready),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_addr(pix_addr),
  .pix_rgb(pix_rgb), .xfer_done(xfer_done), .dirty_ack(dirty_ack),
  .dirty_x0(dirty_x0), .dirty_y0(dirty_y0), .dirty_x1(dirty_x1), .dirty_y1(dirty_y1)
);

// File: tb/sim_win_pixel_writer.sv
module sim_win_pixel_writer;
  localparam int CLK_P = 10;
  localparam int CW = 4;
  localparam int PW = 16;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] wx0 = 0, wy0 = 0, wx1 = 0, wy1 = 0;
  logic [3:0] fmt = 1;
  logic [2:0] src = 0;
  logic src_wr = 0, in_valid = 0, in_ready, pix_valid, pix_ready = 1;
  logic [15:0] in_data = 0;
  logic [AW-1:0] pix_addr;
  logic [23:0] pix_rgb;
  logic xfer_done, dirty_ack = 0;
  logic [CW-1:0] dx0, dy0;
  logic [CW:0] dx1, dy1;

  int checks = 0, errors = 0, got_n = 0, done_cnt = 0, cyc = 0;
  bit stall_en = 0, hold = 0, finished = 0;
  int got_addr [512];
  int got_rgb [512];
  int mnx = 15, mny = 15, mxx = 0, mxy = 0;

  win_pixel_writer #(.COORD_W(CW), .PANEL_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .win_x0(wx0), .win_y0(wy0), .win_x1(wx1), .win_y1(wy1),
    .fmt_code(fmt), .src_sel(src), .src_sel_wr(src_wr), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_addr(pix_addr), .pix_rgb(pix_rgb), .xfer_done(xfer_done), .dirty_ack(dirty_ack),
    .dirty_x0(dx0), .dirty_y0(dy0), .dirty_x1(dx1), .dirty_y1(dy1)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    pix_ready = hold ? 1'b0 : (stall_en ? (cyc % 3 != 0) : 1'b1);
  end

  always @(negedge clk) if (rst_n) begin
    if (pix_valid && pix_ready) begin
      if (got_n < 512) begin got_addr[got_n] = int'(pix_addr); got_rgb[got_n] = int'(pix_rgb); end
      got_n = got_n + 1;
    end
    if (xfer_done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bpp_of(input int f);
    case (f) 1: return 2; 2, 3: return 3; 5, 6: return 4; default: return 0; endcase
  endfunction

  function automatic logic [7:0] gen(input int k, input int seed);
    return 8'((k * 29 + seed * 7 + 3) & 255);
  endfunction

  function automatic int exp_rgb(input int b, input int p, input int seed);
    logic [15:0] w;
    logic [7:0] b0, b1, b2;
    b0 = gen(p*b, seed); b1 = gen(p*b+1, seed); b2 = gen(p*b+2, seed);
    w = {b1, b0};
    if (b == 2) return int'({w[15:11], 3'b0, w[10:5], 2'b0, w[4:0], 3'b0});
    return int'({b2, b1, b0});
  endfunction

  task automatic put_byte(input logic [15:0] d, input bit ack_too);
    in_valid = 1; in_data = d; dirty_ack = ack_too;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0; dirty_ack = 0;
  endtask

  task automatic src_write(input int v);
    src = 3'(v); src_wr = 1;
    @(negedge clk);
    chk(in_ready == 0, "R4 in_ready low on src write", int'(in_ready), 0);
    @(posedge clk); #1;
    src_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_win(input int sx, input int sy, input int ex, input int ey, input int f);
    wx0 = CW'(sx); wy0 = CW'(sy); wx1 = CW'(ex); wy1 = CW'(ey); fmt = 4'(f);
  endtask

  task automatic check_box(input string tag);
    chk(int'(dx0) == mnx, tag, int'(dx0), mnx);
    chk(int'(dy0) == mny, tag, int'(dy0), mny);
    chk(int'(dx1) == mxx, tag, int'(dx1), mxx);
    chk(int'(dy1) == mxy, tag, int'(dy1), mxy);
  endtask

  task automatic run_xfer(input int sx, input int sy, input int ex, input int ey,
                          input int f, input int seed, input bit ack_last, input bit via_src);
    int b, w, h, total, n;
    set_win(sx, sy, ex, ey, f);
    b = bpp_of(f); w = ex - sx + 1; h = ey - sy + 1; total = b * w * h;
    got_n = 0; done_cnt = 0;
    if (via_src) src_write(0);
    for (int k = 0; k < total; k++)
      put_byte({8'hA5 ^ 8'(k), gen(k, seed)}, ack_last && (k == total - 1));
    idle(8);
    chk(got_n == w * h, "R5 pixel count", got_n, w * h);
    n = (got_n < w * h) ? got_n : w * h;
    for (int p = 0; p < n; p++) begin
      int ea, er;
      ea = (sy + p / w) * PW + sx + p % w;
      er = exp_rgb(b, p, seed);
      chk(got_addr[p] == ea, "R8 address", got_addr[p], ea);
      chk(got_rgb[p] == er, (b == 2) ? "R6 565 expand" : "R7 byte order", got_rgb[p], er);
    end
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    if (ack_last) begin
      mnx = sx; mny = sy; mxx = ex + 1; mxy = ey + 1;
    end else begin
      if (sx < mnx) mnx = sx;
      if (sy < mny) mny = sy;
      if (ex + 1 > mxx) mxx = ex + 1;
      if (ey + 1 > mxy) mxy = ey + 1;
    end
    check_box(ack_last ? "R11 ack with commit" : "R10 dirty union");
  endtask

  task automatic reject_case(input string tag);
    got_n = 0; done_cnt = 0;
    for (int k = 0; k < 5; k++) put_byte(16'(k + 1), 0);
    idle(4);
    chk(got_n == 0, tag, got_n, 0);
    chk(done_cnt == 0, tag, done_cnt, 0);
  endtask

  task automatic ack_pulse();
    dirty_ack = 1; @(posedge clk); #1; dirty_ack = 0;
    mnx = 15; mny = 15; mxx = 0; mxy = 0;
  endtask

  initial begin
    int wins [7][4] = '{'{0,0,0,0}, '{3,2,5,2}, '{1,1,1,4}, '{15,15,15,15},
                        '{0,10,15,11}, '{5,0,7,3}, '{0,0,15,15}};
    int fmts [5] = '{1, 2, 3, 5, 6};
    int t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(1);
    // reset state R10 / R12
    chk(pix_valid == 0, "R12 reset pix_valid", int'(pix_valid), 0);
    chk(in_ready == 1, "R12 reset in_ready", int'(in_ready), 1);
    chk(xfer_done == 0, "R9 reset done", int'(xfer_done), 0);
    check_box("R10 reset empty");

    // main sweep; transfers armed by the first data byte (R3)
    t = 0;
    foreach (fmts[i]) begin
      for (int j = 0; j < 7; j++) begin
        stall_en = (t % 2 == 1);
        run_xfer(wins[j][0], wins[j][1], wins[j][2], wins[j][3], fmts[i], t, (t % 3 == 2), 0);
        t++;
      end
      ack_pulse(); idle(1);
      check_box("R11 ack empties");
    end
    stall_en = 0;

    // rejections R2 / R1
    set_win(2, 2, 3, 3, 1); src_write(4); reject_case("R2 source above 3");
    src_write(0);
    set_win(2, 2, 3, 3, 0); src_write(0); reject_case("R1 format 0 unsupported");
    set_win(2, 2, 3, 3, 4); src_write(0); reject_case("R1 format 4 unsupported");
    set_win(5, 2, 4, 3, 1); src_write(0); reject_case("R2 inverted x");
    set_win(2, 3, 4, 2, 1); src_write(0); reject_case("R2 inverted y");
    // recovery via source write R3 / R4
    run_xfer(2, 3, 4, 3, 3, 77, 0, 1);

    // restart mid-transfer discards half pixel R4
    set_win(2, 3, 4, 3, 1); src_write(1);
    got_n = 0;
    for (int k = 0; k < 3; k++) put_byte(16'h00F0 + 16'(k), 0);
    idle(4);
    chk(got_n == 1, "R4 partial before restart", got_n, 1);
    run_xfer(2, 3, 4, 3, 1, 91, 0, 1);

    // back-pressure R12
    ack_pulse();
    set_win(6, 6, 7, 6, 1);
    hold = 1; idle(2);
    got_n = 0; done_cnt = 0;
    put_byte({8'h00, gen(0, 5)}, 0);
    put_byte({8'h00, gen(1, 5)}, 0);
    in_valid = 1; in_data = {8'h00, gen(2, 5)};
    @(negedge clk);
    chk(pix_valid == 1, "R12 pixel pending", int'(pix_valid), 1);
    chk(in_ready == 0, "R12 input stalled", int'(in_ready), 0);
    idle(3);
    @(negedge clk);
    chk(int'(pix_addr) == 6*PW + 6, "R12 address held", int'(pix_addr), 6*PW + 6);
    chk(int'(pix_rgb) == exp_rgb(2, 0, 5), "R12 data held", int'(pix_rgb), exp_rgb(2, 0, 5));
    @(posedge clk); #1;
    hold = 0;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1; in_valid = 0;
    put_byte({8'h00, gen(3, 5)}, 0);
    idle(6);
    chk(got_n == 2, "R12 both pixels delivered", got_n, 2);
    if (got_n >= 2)
      chk(got_rgb[1] == exp_rgb(2, 1, 5), "R6 second pixel", got_rgb[1], exp_rgb(2, 1, 5));
    chk(done_cnt == 1, "R9 done after stall", done_cnt, 1);
    mnx = 6; mny = 6; mxx = 8; mxy = 7;
    check_box("R10 box after stall");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule